// File: doc/BRIEF.md
# Float to 32-bit integer converter

This block turns a packed single-precision floating-point word into a 32-bit integer, either two's-complement signed or unsigned, as chosen per operation by an input flag. Rounding follows a 2-bit mode input. A separate force-truncate input makes any operation round toward zero whatever the mode says. Alongside the integer the block reports three flags: invalid (the result could not be represented and was saturated), inexact (fraction bits were discarded), and input-denormal (the operand was subnormal).

Internally the operand is sorted into three magnitude bands: too large for any 32-bit integer, between one half and 2^32, and below one half. In the middle band the significand, with its hidden one, is shifted into a 64-bit word. The upper half is the integer part and the lower half is the discarded fraction. Rounding adds a mode-dependent increment to the fraction word, and the carry out bumps the integer. The result is then clamped to the range of the chosen integer type and given its sign. The small band has its own directed-rounding rules.

Result and flags are captured in output registers in the cycle that the valid strobe is high, so each conversion has a latency of one clock.

Top module: `f2i_convert`

## Requirements
- R1: On a clock edge with `in_valid` high, the integer and the three flags are captured and `out_valid` is high for the following cycle. With `in_valid` low, `out_valid` goes low and the integer and flags hold their values. While `rst_n` is low, all outputs are cleared to zero.
- R2: `flag_denorm` is set when the exponent field (bits 30:23) is zero and the mantissa field (bits 22:0) is nonzero.
- R3: A non-NaN operand with biased exponent 159 or more saturates and raises only `flag_invalid`. Signed: 0x7FFFFFFF if positive, 0x80000000 if negative. Unsigned: 0xFFFFFFFF if positive, 0 if negative.
- R4: A NaN operand (exponent field 255, mantissa nonzero) raises only `flag_invalid`. Unsigned conversion ignores its sign bit and returns 0xFFFFFFFF. Signed conversion returns 0x7FFFFFFF or 0x80000000 according to its sign bit.
- R5: In round-toward-zero mode, an in-range operand gives its integer part, with `flag_inexact` set exactly when the discarded fraction is nonzero.
- R6: In round-to-nearest mode, fractions above one half round away from zero, fractions below one half round toward zero, and an exact half goes to the even integer.
- R7: `rnd_mode` encodes 00 nearest, 01 toward +infinity, 10 toward -infinity, 11 toward zero. A directed mode raises the magnitude by one when the fraction is nonzero and the rounding direction points away from zero.
- R8: With `trunc_force` high, the result and flags equal those of mode 11, whatever `rnd_mode` holds.
- R9: In unsigned conversion, a negative operand with magnitude of at least one half whose rounded magnitude is nonzero gives 0 with `flag_invalid` only. A negative operand that rounds to magnitude zero gives 0 with `flag_inexact` when its fraction is nonzero.
- R10: In signed conversion, a rounded magnitude above 0x7FFFFFFF (positive) or above 0x80000000 (negative) is clamped to 0x7FFFFFFF or 0x80000000 with `flag_invalid` and without `flag_inexact`.
- R11: A nonzero operand with biased exponent below 126 gives 0 with `flag_inexact`. Exceptions: under +infinity rounding a positive operand gives 1; under -infinity rounding a negative operand gives 0xFFFFFFFF when signed, or 0 with both `flag_invalid` and `flag_inexact` when unsigned. A zero operand of either sign gives 0 with no flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Capture strobe for the current operand |
| in_value | input | 32 | Packed single-precision operand |
| is_signed | input | 1 | 1: signed result, 0: unsigned result |
| trunc_force | input | 1 | Force round toward zero |
| rnd_mode | input | 2 | Rounding mode (00 nearest, 01 +inf, 10 -inf, 11 zero) |
| out_valid | output | 1 | Result registers were loaded on the last edge |
| out_int | output | 32 | Converted integer |
| flag_invalid | output | 1 | Result saturated or not representable |
| flag_inexact | output | 1 | Fraction bits were discarded |
| flag_denorm | output | 1 | Operand was subnormal |

## Verification
The assertions assume that every input is a known value on each rising edge where `in_valid` is high. They also assume the operand keeps the field split of sign at bit 31, exponent at bits 30:23 and mantissa below. Their implications reach one edge ahead, so they rely on `in_value`, `is_signed` and `in_valid` being stable across the sampling edge. The stimulus meets all of this by changing inputs only on falling edges and holding `in_valid` low throughout reset. The sweep covers every exponent code with a handful of mantissa shapes, both signs, all four modes, both signednesses and both states of the force-truncate input.

// File: rtl/f2i_pkg.sv
// Package: shared encodings for the float-to-integer converter.
// Assumes: rounding mode codes as listed in the brief.
package f2i_pkg;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_PLUS    = 2'b01,
        RM_MINUS   = 2'b10,
        RM_ZERO    = 2'b11
    } rmode_e;

    typedef enum logic [1:0] {
        CAT_SMALL = 2'b00,
        CAT_MID   = 2'b01,
        CAT_BIG   = 2'b10
    } mag_cat_e;

endpackage

// File: rtl/f2i_decode.sv
// f2i_decode: splits the packed operand into fields, classifies its
// magnitude band, builds the left-justified significand and the shift
// count, and resolves the effective sign and rounding mode.
// Assumes: INT_W >= MAN_W + 2; the shift count is only meaningful in the
// middle band, where it lies between 0 and INT_W.
module f2i_decode
    import f2i_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int INT_W = 32,
    localparam int FW   = 1 + EXP_W + MAN_W,
    localparam int SH_W = $clog2(INT_W + 1)
) (
    input  logic [FW-1:0]    in_value,
    input  logic             is_signed,
    input  logic             trunc_force,
    input  logic [1:0]       rnd_mode,
    output logic             sign_eff,
    output logic [INT_W-1:0] sig_top,
    output logic [SH_W-1:0]  shift_amt,
    output mag_cat_e         cat,
    output logic             nonzero,
    output logic             denorm,
    output rmode_e           mode_eff
);
    localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
    localparam int SAT_EXP  = BIAS + INT_W;
    localparam int HALF_EXP = BIAS - 1;
    localparam int TOP_EXP  = BIAS + INT_W - 1;
    localparam int PAD_W    = INT_W - 1 - MAN_W;

    logic             sgn;
    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    logic [EXP_W:0]   exp_x;
    logic             hidden;
    logic             is_nan;

    // Field split and operand class.
    always_comb begin
        sgn    = in_value[FW-1];
        exp_f  = in_value[FW-2 -: EXP_W];
        man_f  = in_value[MAN_W-1:0];
        exp_x  = {1'b0, exp_f};
        hidden = |exp_f;
        is_nan = (&exp_f) & (|man_f);
    end

    // Sign: an unsigned conversion drops the sign of a NaN first.
    assign sign_eff = sgn & ~(is_nan & ~is_signed);

    // Significand with hidden one at the top bit, i.e. already doubled.
    assign sig_top = {hidden, man_f, {PAD_W{1'b0}}};

    // Right-shift count; modulo arithmetic is exact inside the middle band.
    assign shift_amt = SH_W'(TOP_EXP) - exp_f[SH_W-1:0];

    // Magnitude band from the biased exponent.
    always_comb begin
        if (exp_x >= (EXP_W+1)'(SAT_EXP))       cat = CAT_BIG;
        else if (exp_x >= (EXP_W+1)'(HALF_EXP)) cat = CAT_MID;
        else                                    cat = CAT_SMALL;
    end

    assign nonzero  = |in_value[FW-2:0];
    assign denorm   = ~hidden & (|man_f);
    assign mode_eff = trunc_force ? RM_ZERO : rmode_e'(rnd_mode);

endmodule

// File: rtl/f2i_round.sv
// f2i_round: aligns the significand into an integer part and a fraction
// word, forms the mode-dependent increment and applies the carry.
// Assumes: shift_amt in 0..INT_W; a carry into an all-ones integer part is
// reported instead of wrapping.
module f2i_round
    import f2i_pkg::*;
#(
    parameter int INT_W = 32,
    localparam int SH_W = $clog2(INT_W + 1)
) (
    input  logic [INT_W-1:0] sig_top,
    input  logic [SH_W-1:0]  shift_amt,
    input  rmode_e           mode,
    input  logic             sign,
    output logic [INT_W-1:0] int_rnd,
    output logic             sat_carry,
    output logic             rem_nz
);
    localparam logic [INT_W-1:0] HALF_W = {1'b1, {(INT_W-1){1'b0}}};

    logic [2*INT_W-1:0] wide;
    logic [INT_W-1:0]   int_part;
    logic [INT_W-1:0]   frac;
    logic [INT_W-1:0]   incr;
    logic [INT_W-1:0]   fsum;
    logic               carry;

    // Alignment: upper half integer part, lower half discarded fraction.
    always_comb begin
        wide     = {sig_top, {INT_W{1'b0}}} >> shift_amt;
        int_part = wide[2*INT_W-1:INT_W];
        frac     = wide[INT_W-1:0];
    end

    // Increment selection per rounding mode.
    always_comb begin
        unique case (mode)
            RM_NEAREST: incr = int_part[0] ? HALF_W : HALF_W - 1'b1;
            RM_PLUS:    incr = sign ? '0 : '1;
            RM_MINUS:   incr = sign ? '1 : '0;
            default:    incr = '0;
        endcase
    end

    // Carry detection out of the fraction word.
    always_comb begin
        fsum  = frac + incr;
        carry = fsum < frac;
    end

    // Apply the carry unless the integer part is already full.
    always_comb begin
        sat_carry = carry & (&int_part);
        int_rnd   = (carry & ~(&int_part)) ? int_part + 1'b1 : int_part;
        rem_nz    = |frac;
    end

endmodule

// File: rtl/f2i_finish.sv
// f2i_finish: chooses the final integer and flags per magnitude band,
// applying the signed or unsigned clamp rules and the sign.
// Assumes: int_rnd, sat_carry and rem_nz are only meaningful in the middle band.
module f2i_finish
    import f2i_pkg::*;
#(
    parameter int INT_W = 32
) (
    input  mag_cat_e         cat,
    input  logic             sign,
    input  logic             is_signed,
    input  logic             nonzero,
    input  logic             denorm,
    input  rmode_e           mode,
    input  logic [INT_W-1:0] int_rnd,
    input  logic             sat_carry,
    input  logic             rem_nz,
    output logic [INT_W-1:0] result,
    output logic             inv,
    output logic             inx,
    output logic             den
);
    localparam logic [INT_W-1:0] MAX_POS = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] MIN_MAG = {1'b1, {(INT_W-1){1'b0}}};

    logic [INT_W-1:0] lim;
    logic [INT_W-1:0] mag;

    // Band-wise selection of result and flags.
    always_comb begin
        result = '0;
        inv    = 1'b0;
        inx    = 1'b0;
        den    = denorm;
        lim    = sign ? MIN_MAG : MAX_POS;
        mag    = int_rnd;
        unique case (cat)
            CAT_BIG: begin
                den = 1'b0;
                inv = 1'b1;
                if (is_signed) result = sign ? MIN_MAG : MAX_POS;
                else           result = sign ? '0 : '1;
            end
            CAT_MID: begin
                if (!is_signed) begin
                    result = int_rnd;
                    inv    = sat_carry;
                    if (sign && (int_rnd != '0)) begin
                        result = '0;
                        inv    = 1'b1;
                    end else if (rem_nz) begin
                        inx = 1'b1;
                    end
                end else begin
                    if (mag > lim) begin
                        mag = lim;
                        inv = 1'b1;
                    end else if (rem_nz) begin
                        inx = 1'b1;
                    end
                    result = sign ? (~mag + 1'b1) : mag;
                end
            end
            default: begin
                if (nonzero) begin
                    inx = 1'b1;
                    if (mode == RM_PLUS && !sign) begin
                        result = {{(INT_W-1){1'b0}}, 1'b1};
                    end else if (mode == RM_MINUS && sign) begin
                        if (is_signed) result = '1;
                        else           inv    = 1'b1;
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/f2i_convert.sv
// f2i_convert: packed single-precision to signed/unsigned integer
// converter with one register stage on the valid strobe.
// Assumes: inputs are stable around the capturing edge; reset is
// synchronous and active low.
module f2i_convert
    import f2i_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int INT_W = 32,
    localparam int FW   = 1 + EXP_W + MAN_W,
    localparam int SH_W = $clog2(INT_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [FW-1:0]    in_value,
    input  logic             is_signed,
    input  logic             trunc_force,
    input  logic [1:0]       rnd_mode,
    output logic             out_valid,
    output logic [INT_W-1:0] out_int,
    output logic             flag_invalid,
    output logic             flag_inexact,
    output logic             flag_denorm
);
    logic             sign_eff;
    logic [INT_W-1:0] sig_top;
    logic [SH_W-1:0]  shift_amt;
    mag_cat_e         cat;
    logic             nonzero;
    logic             denorm;
    rmode_e           mode_eff;
    logic [INT_W-1:0] int_rnd;
    logic             sat_carry;
    logic             rem_nz;
    logic [INT_W-1:0] res_c;
    logic             inv_c;
    logic             inx_c;
    logic             den_c;

    f2i_decode #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_decode (
        .in_value    (in_value),
        .is_signed   (is_signed),
        .trunc_force (trunc_force),
        .rnd_mode    (rnd_mode),
        .sign_eff    (sign_eff),
        .sig_top     (sig_top),
        .shift_amt   (shift_amt),
        .cat         (cat),
        .nonzero     (nonzero),
        .denorm      (denorm),
        .mode_eff    (mode_eff)
    );

    f2i_round #(.INT_W(INT_W)) u_round (
        .sig_top   (sig_top),
        .shift_amt (shift_amt),
        .mode      (mode_eff),
        .sign      (sign_eff),
        .int_rnd   (int_rnd),
        .sat_carry (sat_carry),
        .rem_nz    (rem_nz)
    );

    f2i_finish #(.INT_W(INT_W)) u_finish (
        .cat       (cat),
        .sign      (sign_eff),
        .is_signed (is_signed),
        .nonzero   (nonzero),
        .denorm    (denorm),
        .mode      (mode_eff),
        .int_rnd   (int_rnd),
        .sat_carry (sat_carry),
        .rem_nz    (rem_nz),
        .result    (res_c),
        .inv       (inv_c),
        .inx       (inx_c),
        .den       (den_c)
    );

    // Output stage: capture on the strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_int      <= '0;
            flag_invalid <= 1'b0;
            flag_inexact <= 1'b0;
            flag_denorm  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_int      <= res_c;
                flag_invalid <= inv_c;
                flag_inexact <= inx_c;
                flag_denorm  <= den_c;
            end
        end
    end

endmodule

// File: rtl/f2i_checker.sv
// f2i_checker: port-level properties of f2i_convert, bound to every instance.
// Assumes: known inputs on capturing edges.
module f2i_checker #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int INT_W = 32,
    localparam int FW   = 1 + EXP_W + MAN_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [FW-1:0]    in_value,
    input logic             is_signed,
    input logic             out_valid,
    input logic [INT_W-1:0] out_int,
    input logic             flag_invalid,
    input logic             flag_inexact,
    input logic             flag_denorm
);
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int SAT_EXP = BIAS + INT_W;

    logic [EXP_W-1:0] e_f;
    logic [MAN_W-1:0] m_f;
    logic             nan_in;
    logic             huge_in;
    logic             zero_in;

    // Operand field view for the properties.
    always_comb begin
        e_f     = in_value[FW-2 -: EXP_W];
        m_f     = in_value[MAN_W-1:0];
        nan_in  = (&e_f) & (|m_f);
        huge_in = {1'b0, e_f} >= (EXP_W+1)'(SAT_EXP);
        zero_in = ~(|in_value[FW-2:0]);
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid) else $error("valid pulse lost"); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_int) && $stable(flag_invalid))) else $error("idle hold broken"); // R1

    AST_DENORM_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && e_f == '0 && m_f != '0) |=> flag_denorm) else $error("denormal not flagged"); // R2

    AST_HUGE_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && huge_in && !nan_in) |=> (flag_invalid && !flag_inexact && !flag_denorm)) else $error("huge input flags"); // R3

    AST_UNSIGNED_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_signed && in_value[FW-1] && !nan_in) |=> (out_int == '0)) else $error("negative unsigned result"); // R9

    AST_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && zero_in) |=> (out_int == '0 && !flag_invalid && !flag_inexact && !flag_denorm)) else $error("zero input not quiet"); // R11

endmodule

bind f2i_convert f2i_checker #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_check (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_value     (in_value),
    .is_signed    (is_signed),
    .out_valid    (out_valid),
    .out_int      (out_int),
    .flag_invalid (flag_invalid),
    .flag_inexact (flag_inexact),
    .flag_denorm  (flag_denorm)
);

// File: tb/sim_f2i_convert.sv
`timescale 1ns/1ps
module sim_f2i_convert;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_value = '0;
    logic        is_signed = 1'b0;
    logic        trunc_force = 1'b0;
    logic [1:0]  rnd_mode = 2'b00;
    logic        out_valid;
    logic [31:0] out_int;
    logic        flag_invalid;
    logic        flag_inexact;
    logic        flag_denorm;

    int          n_cmp = 0;
    int          n_bad = 0;
    logic [31:0] xs = 32'h1234_5679;

    always #2 clk = ~clk;

    f2i_convert u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_value     (in_value),
        .is_signed    (is_signed),
        .trunc_force  (trunc_force),
        .rnd_mode     (rnd_mode),
        .out_valid    (out_valid),
        .out_int      (out_int),
        .flag_invalid (flag_invalid),
        .flag_inexact (flag_inexact),
        .flag_denorm  (flag_denorm)
    );

    task automatic check(input string tag, input logic [34:0] got, input logic [34:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: in=%h got int=%h inv=%b inx=%b den=%b expected int=%h inv=%b inx=%b den=%b",
                     tag, in_value, got[34:3], got[2], got[1], got[0], exp[34:3], exp[2], exp[1], exp[0]);
        end
    endtask

    // Arithmetic reference: exact fixed-point magnitude, then rounding and clamping.
    function automatic logic [34:0] ref_model(input logic [31:0] v, input bit sgd, input bit tf, input logic [1:0] rm);
        bit          sgn = v[31];
        int          e = int'(v[30:23]);
        logic [22:0] man = v[22:0];
        bit          nz = (v[30:0] != 0);
        bit          nan = (e == 255) && (man != 0);
        bit          den = (e == 0) && (man != 0);
        logic [1:0]  mode = tf ? 2'b11 : rm;
        logic [95:0] fx;
        logic [63:0] ip;
        logic [31:0] frac;
        logic [63:0] r;
        bit          up;
        logic [31:0] res;
        bit          inv = 0;
        bit          inx = 0;
        if (e >= 159) begin
            if (!sgd && nan) sgn = 0;
            if (sgd) res = sgn ? 32'h8000_0000 : 32'h7FFF_FFFF;
            else     res = sgn ? 32'h0 : 32'hFFFF_FFFF;
            return {res, 1'b1, 1'b0, 1'b0};
        end
        if (e >= 118) begin
            fx   = 96'({(e != 0), man}) << (e - 118);
            ip   = fx[95:32];
            frac = fx[31:0];
        end else begin
            ip   = 0;
            frac = nz ? 32'd1 : 32'd0;
        end
        case (mode)
            2'b00:   up = (frac > 32'h8000_0000) || (frac == 32'h8000_0000 && ip[0]);
            2'b01:   up = (frac != 0) && !sgn;
            2'b10:   up = (frac != 0) && sgn;
            default: up = 0;
        endcase
        r = ip + 64'(up);
        if (sgd) begin
            if (!sgn && r > 64'h7FFF_FFFF) begin res = 32'h7FFF_FFFF; inv = 1; end
            else if (sgn && r > 64'h8000_0000) begin res = 32'h8000_0000; inv = 1; end
            else begin res = sgn ? (~r[31:0] + 32'd1) : r[31:0]; inx = (frac != 0); end
        end else begin
            if (sgn && r != 0) begin res = 0; inv = 1; inx = (e < 126); end
            else if (r > 64'hFFFF_FFFF) begin res = 32'hFFFF_FFFF; inv = 1; end
            else begin res = r[31:0]; inx = (frac != 0); end
        end
        return {res, inv, inx, den};
    endfunction

    function automatic string req_tag(input logic [31:0] v, input bit sgd, input bit tf, input logic [1:0] rm);
        int e = int'(v[30:23]);
        if (e == 255 && v[22:0] != 0) return "R4";
        if (e >= 159) return "R3";
        if (e < 126) return "R11";
        if (sgd && e >= 157) return "R10";
        if (!sgd && v[31]) return "R9";
        if (tf && rm != 2'b11) return "R8";
        if (rm == 2'b00) return "R6";
        if (rm == 2'b11) return "R5";
        return "R7";
    endfunction

    function automatic logic [22:0] man_pattern(input int p, input logic [31:0] rnd);
        case (p)
            0: return 23'h000000;
            1: return 23'h000001;
            2: return 23'h400000;
            3: return 23'h7FFFFF;
            default: return rnd[22:0];
        endcase
    endfunction

    initial begin
        logic [34:0] held;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset outputs", {out_int, flag_invalid, flag_inexact, flag_denorm}, 35'd0);
        check("R1 reset valid", 35'(out_valid), 35'd0);
        @(negedge clk) rst_n = 1'b1;
        for (int e = 0; e < 256; e++) begin
            for (int p = 0; p < 5; p++) begin
                for (int c = 0; c < 32; c++) begin
                    xs = xs ^ (xs << 13);
                    xs = xs ^ (xs >> 17);
                    xs = xs ^ (xs << 5);
                    @(negedge clk);
                    in_value    = {c[4], e[7:0], man_pattern(p, xs)};
                    is_signed   = c[0];
                    trunc_force = c[1];
                    rnd_mode    = c[3:2];
                    in_valid    = 1'b1;
                    @(posedge clk);
                    #1;
                    check(req_tag(in_value, c[0], c[1], c[3:2]),
                          {out_int, flag_invalid, flag_inexact, flag_denorm},
                          ref_model(in_value, c[0], c[1], c[3:2]));
                    if (e == 0) check("R2", 35'(flag_denorm), 35'(in_value[22:0] != 0));
                    if (c == 0 && p == 0) check("R1 strobe", 35'(out_valid), 35'd1);
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        held     = {out_int, flag_invalid, flag_inexact, flag_denorm};
        in_value = 32'h4F80_0000;
        repeat (3) @(posedge clk);
        #1;
        check("R1 hold", {out_int, flag_invalid, flag_inexact, flag_denorm}, held);
        check("R1 idle valid", 35'(out_valid), 35'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R1: watchdog got no completion expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule